// File: doc/BRIEF.md
# Receive ring writer with length-prefixed entries

This block accepts received Ethernet frames as a byte stream and stores them in a circular buffer held in a word-addressed memory. Every stored entry is a 32-bit length word followed by the frame bytes. The block packs incoming bytes into 32-bit words little-endian and drives one memory write port. The length word goes into the slot at the head of the entry only once the whole frame is in memory. A reader that sees a non-zero length word can therefore trust the data behind it.

The block keeps a byte-address input pointer and publishes it, so software can compare it with its own output pointer. The two pointers are equal when the buffer is empty. The tail of the buffer may become too short to hold a maximum-size entry. When that happens and the buffer is idle, the block writes a zero word at the input pointer as an in-band wrap marker and reloads the pointer from the start address.

Frames are dropped in three cases: they are too long, they would run into data not yet read, or the wrap is blocked. Frames that end with the error flag are discarded silently. In every one of these cases the pointer stays where it was. The frame source must leave at least two idle cycles after each frame's last byte, which is well inside any inter-frame gap.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `in_ptr` equals `cfg_start`, `mem_we` is 0 and `drop` is 0.
- R2: Frame byte k is stored at byte address `in_ptr + 4 + k`. Bytes are packed little-endian: byte 4m goes to bits 7:0 of its word and byte 4m+3 to bits 31:24. In a final partial word, the unused upper bytes are written as zero.
- R3: For an accepted frame of n bytes, the value n is written to the word at `in_ptr`. This write is the last write of the frame and comes after every data word.
- R4: After that write, `in_ptr` becomes `in_ptr + 4 + 4*ceil(n/4)`. It is always a multiple of 4.
- R5: While idle, if `cfg_last - in_ptr < MAX_ENTRY` (where `MAX_ENTRY = 4 + 4*ceil(MAX_FRAME/4)`), `out_ptr <= in_ptr` and `out_ptr != cfg_start`, then the block writes 32'h00000000 at `in_ptr` and sets `in_ptr` to `cfg_start`.
- R6: If the tail is short but the wrap is not allowed (`out_ptr == cfg_start`, or `out_ptr > in_ptr`), then `in_ptr` holds, no marker is written, and every frame that arrives is dropped. Once `out_ptr` allows it, the wrap of R5 takes place.
- R7: If `out_ptr > in_ptr` and `in_ptr + 4 + 4*ceil(n/4) >= out_ptr`, the frame is dropped. In that case `in_ptr` is unchanged, the word at `in_ptr` is not written, and `drop` is high for one cycle, in the cycle after the frame's last byte is accepted.
- R8: A frame longer than `MAX_FRAME` bytes is dropped in the same way as in R7.
- R9: A frame whose last byte carries `in_err` = 1 (and that is not dropped for R6 to R8) leaves `in_ptr` unchanged. Its length word is not written, and `drop` stays 0.
- R10: Every memory write falls inside the byte range from `cfg_start` to `cfg_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | ADDR_W | Byte address of the first buffer word (word aligned) |
| cfg_last | input | ADDR_W | Byte address of the last buffer word (word aligned) |
| out_ptr | input | ADDR_W | Software read pointer, byte address |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| in_err | input | 1 | The frame is bad (sampled with in_last) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| in_ptr | output | ADDR_W | Input pointer, byte address |
| drop | output | 1 | One-cycle pulse per dropped frame |

## Verification
The bench checks frame lengths 1, 4, 5, 8 and 60. These show whether the byte lanes and the zero fill are right, and whether the pointer is rounded correctly: an off-by-one in the rounding would leave a gap or an overlap between entries. It fills the tail until a wrap is due and checks both the zero marker and the reload. It then blocks the wrap by parking `out_ptr` at the start address. A design that wrapped anyway would make a full buffer look empty. It also sends one frame that would land exactly on `out_ptr`, which must be dropped while the old length word there stays intact. Error-flagged frames and oversized frames are sent as well: a design that committed either one would publish garbage as a valid entry.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int ADDR_W    = 16,
  parameter int MAX_FRAME = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [ADDR_W-1:0] cfg_last,
  input  logic [ADDR_W-1:0] out_ptr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [ADDR_W-1:0] in_ptr,
  output logic              drop
);

  localparam int MAX_ENTRY = 4 + ((MAX_FRAME + 3) / 4) * 4;
  localparam int CNT_W     = $clog2(MAX_FRAME + 2);
  localparam int EW        = ADDR_W + 1;
  localparam logic [CNT_W-1:0] MAX_LEN  = CNT_W'(MAX_FRAME);
  localparam logic [EW-1:0]    ENTRY_SZ = EW'(MAX_ENTRY);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_SKIP, S_SIZE} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [31:0]       lanes;
  logic [31:0]       wd;
  logic [1:0]        lane;
  logic [CNT_W-1:0]  n_next;
  logic [EW-1:0]     end_next;
  logic [EW-1:0]     end_done;
  logic [ADDR_W-1:0] data_addr;
  logic              need_wrap;
  logic              wrap_ok;
  logic              reject;

  function automatic logic [EW-1:0] span(input logic [CNT_W-1:0] n);
    return (EW'(n) + EW'(3)) & ~EW'(3);
  endfunction

  assign lane      = cnt[1:0];
  assign n_next    = cnt + CNT_W'(1);
  assign end_next  = EW'(in_ptr) + EW'(4) + span(n_next);
  assign end_done  = EW'(in_ptr) + EW'(4) + span(cnt);
  assign data_addr = in_ptr + ADDR_W'(4) + ADDR_W'({cnt[CNT_W-1:2], 2'b00});
  assign need_wrap = (EW'(cfg_last) - EW'(in_ptr)) < ENTRY_SZ;
  assign wrap_ok   = (out_ptr <= in_ptr) && (out_ptr != cfg_start);
  assign reject    = (n_next > MAX_LEN)
                   || ((out_ptr > in_ptr) && (end_next >= EW'(out_ptr)))
                   || ((st == S_IDLE) && need_wrap);

  always_comb begin
    wd = lanes;
    wd[{lane, 3'b000} +: 8] = in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      lanes     <= '0;
      in_ptr    <= cfg_start;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      drop      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      drop   <= 1'b0;
      case (st)
        S_IDLE, S_RECV: begin
          if (in_valid) begin
            if (reject) begin
              cnt   <= '0;
              lanes <= '0;
              if (in_last) begin
                drop <= 1'b1;
                st   <= S_IDLE;
              end else begin
                st <= S_SKIP;
              end
            end else begin
              cnt <= (in_last && in_err) ? '0 : n_next;
              if (lane == 2'd3 || in_last) begin
                mem_we    <= 1'b1;
                mem_addr  <= data_addr[ADDR_W-1:2];
                mem_wdata <= wd;
                lanes     <= '0;
              end else begin
                lanes <= wd;
              end
              if (in_last) st <= in_err ? S_IDLE : S_SIZE;
              else         st <= S_RECV;
            end
          end else if (st == S_IDLE && need_wrap && wrap_ok) begin
            mem_we    <= 1'b1;
            mem_addr  <= in_ptr[ADDR_W-1:2];
            mem_wdata <= '0;
            in_ptr    <= cfg_start;
          end
        end
        S_SKIP: begin
          if (in_valid && in_last) begin
            drop <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_SIZE: begin
          mem_we    <= 1'b1;
          mem_addr  <= in_ptr[ADDR_W-1:2];
          mem_wdata <= 32'(cnt);
          in_ptr    <= end_done[ADDR_W-1:0];
          cnt       <= '0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ptr[1:0] == 2'b00); // R4

  AST_PTR_MOVES_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_ptr) |-> mem_we); // R3

  AST_WRAP_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(in_ptr) && in_ptr == cfg_start) |-> (mem_wdata == 32'h0)); // R5

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(in_ptr) && $past(out_ptr) > $past(in_ptr)) |-> (in_ptr < $past(out_ptr))); // R7

  AST_WRITE_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({mem_addr, 2'b00} >= cfg_start && {mem_addr, 2'b00} <= cfg_last)); // R10

endmodule

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  localparam int ADDR_W = 16;
  localparam int MAXF   = 64;
  localparam int ENTRY  = 4 + ((MAXF + 3) / 4) * 4;
  localparam int START  = 'h100;
  localparam int LAST   = 'h1FC;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_start = ADDR_W'(START);
  logic [ADDR_W-1:0] cfg_last  = ADDR_W'(LAST);
  logic [ADDR_W-1:0] sw_out    = ADDR_W'(START);
  logic              in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic [7:0]        in_data = 8'h0;
  logic              mem_we, drop;
  logic [ADDR_W-3:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic [ADDR_W-1:0] in_ptr;

  rx_ring_writer #(.ADDR_W(ADDR_W), .MAX_FRAME(MAXF)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_last(cfg_last),
    .out_ptr(sw_out), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .in_ptr(in_ptr), .drop(drop));

  logic [31:0] mem [int];
  int last_wr = -1;
  int drops = 0, bad_range = 0;
  int checks = 0, errors = 0;
  int exp_ptr = START;
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      mem[int'({mem_addr, 2'b00})] = mem_wdata;
      last_wr = int'({mem_addr, 2'b00});
      if (int'({mem_addr, 2'b00}) < START || int'({mem_addr, 2'b00}) > LAST) bad_range++;
    end
    if (drop) drops++;
  end

  function automatic logic [31:0] rd(int a);
    return mem.exists(a) ? mem[a] : 32'hDEAD_BEEF;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(int n, logic [7:0] seed, bit err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seed + 8'(i);
      in_last  = (i == n - 1);
      in_err   = err && (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic good_frame(int n, logic [7:0] seed);
    int old = exp_ptr;
    int adv = old + 4 + ((n + 3) / 4) * 4;
    bit wrap = ((LAST - adv) < ENTRY) && (int'(sw_out) <= adv) && (int'(sw_out) != START);
    logic [31:0] e;
    send(n, seed, 1'b0);
    for (int w = 0; w < (n + 3) / 4; w++) begin
      e = 32'h0;
      for (int b = 0; b < 4; b++) if (4 * w + b < n) e[8*b +: 8] = seed + 8'(4 * w + b);
      chk("R2", $sformatf("data word %0d of %0d-byte frame", w, n), rd(old + 4 + 4 * w), e);
    end
    chk("R3", "length word", rd(old), 32'(n));
    if (wrap) begin
      chk("R5", "zero marker at tail", rd(adv), 32'h0);
      chk("R5", "pointer reloaded", 32'(in_ptr), 32'(START));
      chk("R5", "marker is last write", 32'(last_wr), 32'(adv));
      exp_ptr = START;
    end else begin
      chk("R3", "length word is last write", 32'(last_wr), 32'(old));
      chk("R4", "pointer advance", 32'(in_ptr), 32'(adv));
      exp_ptr = adv;
    end
  endtask

  task automatic bad_frame(string req, int n, logic [7:0] seed, bit err, bit expect_drop);
    int d = drops;
    send(n, seed, err);
    chk(req, "pointer unchanged", 32'(in_ptr), 32'(exp_ptr));
    chk(req, "drop pulses", 32'(drops), 32'(d + (expect_drop ? 1 : 0)));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pointer at start", 32'(in_ptr), 32'(START));
    chk("R1", "no write", 32'(mem_we), 32'h0);
    chk("R1", "no drop", 32'(drop), 32'h0);
  endtask

  task automatic t_lengths();
    good_frame(5, 8'h11);
    good_frame(4, 8'h21);
    good_frame(8, 8'h31);
    good_frame(1, 8'h41);
  endtask

  task automatic t_error();
    bad_frame("R9", 6, 8'h51, 1'b1, 1'b0);
    chk("R9", "length slot untouched", 32'(mem.exists(exp_ptr)), 32'h0);
  endtask

  task automatic t_oversize();
    bad_frame("R8", MAXF + 1, 8'h02, 1'b0, 1'b1);
  endtask

  task automatic t_wrap();
    sw_out = ADDR_W'(exp_ptr);
    good_frame(60, 8'h10);
    good_frame(60, 8'h20);
    good_frame(60, 8'h30);
    chk("R5", "wrapped to start", 32'(exp_ptr), 32'(START));
  endtask

  task automatic t_overflow();
    bad_frame("R7", 36, 8'h60, 1'b0, 1'b1);
    chk("R7", "old length word intact", rd(START), 32'd5);
    good_frame(32, 8'h70);
  endtask

  task automatic t_blocked();
    sw_out = ADDR_W'(exp_ptr);
    good_frame(60, 8'h08);
    good_frame(60, 8'h18);
    sw_out = ADDR_W'(START);
    good_frame(60, 8'h28);
    repeat (4) @(negedge clk);
    chk("R6", "pointer holds while blocked", 32'(in_ptr), 32'(exp_ptr));
    chk("R6", "no marker while blocked", 32'(rd(exp_ptr) == 32'h0), 32'h0);
    bad_frame("R6", 10, 8'h48, 1'b0, 1'b1);
    sw_out = ADDR_W'(START + 'h20);
    repeat (3) @(negedge clk);
    chk("R6", "marker after release", rd(exp_ptr), 32'h0);
    chk("R6", "pointer reloaded after release", 32'(in_ptr), 32'(START));
    exp_ptr = START;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_reset();
    t_lengths();
    t_error();
    t_oversize();
    t_wrap();
    t_overflow();
    t_blocked();
    chk("R10", "writes outside buffer", 32'(bad_range), 32'h0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule